// File: doc/BRIEF.md
# CAN receive mailbox bank

This block sits behind a CAN protocol core and parks every accepted incoming frame in one of twelve receive mailboxes. Each mailbox keeps the frame's identifier, a status word (length code, remote-request flag, ready and lost-data flags) and eight data bytes. Acceptance filtering is wide open: every frame the core offers is stored. A frame always goes to the lowest-numbered mailbox that is currently free. Mailboxes 0 to 10 run in plain receive mode and are skipped while they hold a message; the top mailbox (11) runs in receive-with-overwrite mode, so when nothing is free the new frame replaces its contents and a lost-data flag is raised.

Software fetches a mailbox through a small combinational read port (mailbox index plus word select) and frees mailboxes by writing a bitmask re-arm command; a set bit i frees mailbox i, so writing the low eight bits frees the whole lower group of eight at once. Reading never frees a mailbox. The hardware keeps no arrival order; ordering is left to the software that chooses what to re-arm.

The frame input is a valid/ready stream. Because the overwrite mailbox can always take a frame, the bank never applies back-pressure: `frm_ready` is held high and a frame is taken on every clock edge where `frm_valid` is high.

Top module: `rxmb_bank`

## Requirements
- R1: After reset every mailbox is empty: `ready_map` is 0, `lost_flag` is 0 and every word read from a mailbox is 0.
- R2: A frame taken on a clock edge sets the ready bit of exactly one mailbox, visible on `ready_map` right after that edge.
- R3: Identifier word (word select 0): for an extended frame bit 29 is 1 and the 29-bit identifier sits in bits 28:0; for a standard frame bit 29 is 0 and the 11-bit identifier sits in bits 28:18; other bits are 0.
- R4: Status word (word select 1): bit 23 is the ready flag, bit 24 the lost-data flag, bit 20 the remote-request flag, bits 19:16 the length code; other bits are 0.
- R5: Word select 2 returns data bytes 0 to 3 (`frm_data[31:0]`), word select 3 returns bytes 4 to 7 (`frm_data[63:32]`).
- R6: The frame is stored in the lowest-numbered mailbox whose ready bit is clear; mailboxes holding a message are skipped.
- R7: When all twelve mailboxes hold a message, a new frame overwrites mailbox 11 and sets its lost-data flag; `lost_flag` mirrors that flag.
- R8: Reading any mailbox word never changes any ready or lost-data flag.
- R9: A re-arm write (`arm_we` high) clears the ready and lost-data flags of exactly the mailboxes whose `arm_mask` bit is set; length code, remote flag, identifier and data stay as stored.
- R10: A re-arm and a frame on the same edge: the re-arm counts first, so the frame can land in a mailbox freed on that edge (ahead of a higher free one) and mailbox 11 freed on that edge is not flagged as lost.
- R11: `ready_map` bit i always equals status bit 23 of mailbox i.
- R12: `frm_ready` is always 1; with `frm_valid` low no mailbox changes whatever the frame fields carry; a read of a mailbox index 12 to 15 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| frm_valid | input | 1 | Frame offered by the protocol core |
| frm_ready | output | 1 | Bank accepts a frame (always 1) |
| frm_ext | input | 1 | 1 = 29-bit identifier, 0 = 11-bit |
| frm_id | input | 29 | Identifier; standard frames use bits 10:0 |
| frm_rtr | input | 1 | Remote-request frame |
| frm_dlc | input | 4 | Data length code |
| frm_data | input | 64 | Data bytes, byte 0 in bits 7:0 |
| arm_we | input | 1 | Re-arm command strobe |
| arm_mask | input | 12 | Bit i frees mailbox i |
| rd_sel | input | 4 | Mailbox index for the read port |
| rd_word | input | 2 | 0 identifier, 1 status, 2 data low, 3 data high |
| rd_data | output | 32 | Selected mailbox word (combinational) |
| ready_map | output | 12 | Bit i = mailbox i holds an unread message |
| lost_flag | output | 1 | Mailbox 11 was overwritten while holding a message |

## Verification
Directed frames of the three shapes (standard, extended, remote) show the word encodings apart, and a re-arm of a middle mailbox followed by a new frame tells lowest-free selection apart from next-in-line filling. Filling all twelve and sending one more separates overwrite behaviour from silently dropping, and a frame coinciding with a re-arm tells whether the re-arm is applied before the slot search. A long random stretch of mixed frames and random re-arm masks is then compared every clock against a behavioural model, which also rotates the read port through every mailbox word.

// File: rtl/rxmb_pkg.sv
package rxmb_pkg;

  localparam int ID_W    = 29;
  localparam int DATA_W  = 64;
  localparam int WORD_W  = 32;

  localparam int ST_RDY  = 23;
  localparam int ST_LOST = 24;
  localparam int ST_RTR  = 20;
  localparam int ST_DLC  = 16;
  localparam int ID_EXT  = 29;
  localparam int STD_SH  = 18;

  typedef enum logic [1:0] {
    W_ID   = 2'd0,
    W_STAT = 2'd1,
    W_DLO  = 2'd2,
    W_DHI  = 2'd3
  } word_sel_e;

  typedef enum logic [2:0] {
    MODE_OFF    = 3'd0,
    MODE_RX     = 3'd1,
    MODE_RX_OVR = 3'd2
  } slot_mode_e;

  typedef struct packed {
    logic              ext;
    logic [ID_W-1:0]   id;
    logic              rtr;
    logic [3:0]        dlc;
    logic [DATA_W-1:0] data;
  } rx_frame_t;

endpackage

// File: rtl/rxmb_pick.sv
module rxmb_pick #(
  parameter int N = 12
) (
  input  logic [N-1:0] free_i,
  output logic [N-1:0] grant_o,
  output logic         any_o
);

  logic [N-1:0] below;

  for (genvar i = 0; i < N; i++) begin : g_chain
    if (i == 0) begin : g_first
      assign below[i] = 1'b0;
    end else begin : g_next
      assign below[i] = below[i-1] | free_i[i-1];
    end
    assign grant_o[i] = free_i[i] & ~below[i];
  end

  assign any_o = |free_i;

endmodule

// File: rtl/rxmb_slot.sv
module rxmb_slot
  import rxmb_pkg::*;
#(
  parameter slot_mode_e MODE = MODE_RX
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              store_i,
  input  logic              rearm_i,
  input  rx_frame_t         frame_i,
  output logic              full_o,
  output logic              lost_o,
  output logic [WORD_W-1:0] id_word_o,
  output logic [WORD_W-1:0] stat_word_o,
  output logic [WORD_W-1:0] dlo_o,
  output logic [WORD_W-1:0] dhi_o
);

  rx_frame_t fr_q;
  logic      full_q;
  logic      lost_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      fr_q   <= '0;
    end else if (store_i) begin
      full_q <= 1'b1;
      fr_q   <= frame_i;
    end else if (rearm_i) begin
      full_q <= 1'b0;
    end
  end

  if (MODE == MODE_RX_OVR) begin : g_ovr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       lost_q <= 1'b0;
      else if (store_i) lost_q <= full_q & ~rearm_i;
      else if (rearm_i) lost_q <= 1'b0;
    end
  end else begin : g_plain
    assign lost_q = 1'b0;
    // a plain slot is only chosen while free
    p_no_clobber_r6: assert property (@(posedge clk) disable iff (!rst_n)
      store_i |-> (!full_q || rearm_i));
  end

  p_rearm_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rearm_i && !store_i) |=> (!full_o && !lost_o));

  assign full_o = full_q;
  assign lost_o = lost_q;

  always_comb begin
    id_word_o = '0;
    if (fr_q.ext) begin
      id_word_o[ID_EXT]    = 1'b1;
      id_word_o[ID_W-1:0]  = fr_q.id;
    end else begin
      id_word_o[STD_SH+10:STD_SH] = fr_q.id[10:0];
    end
    stat_word_o               = '0;
    stat_word_o[ST_RDY]       = full_q;
    stat_word_o[ST_LOST]      = lost_q;
    stat_word_o[ST_RTR]       = fr_q.rtr;
    stat_word_o[ST_DLC+3:ST_DLC] = fr_q.dlc;
  end

  assign dlo_o = fr_q.data[WORD_W-1:0];
  assign dhi_o = fr_q.data[DATA_W-1:WORD_W];

endmodule

// File: rtl/rxmb_bank.sv
module rxmb_bank
  import rxmb_pkg::*;
#(
  parameter  int N_SLOTS = 12,
  localparam int SEL_W   = $clog2(N_SLOTS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frm_valid,
  output logic               frm_ready,
  input  logic               frm_ext,
  input  logic [28:0]        frm_id,
  input  logic               frm_rtr,
  input  logic [3:0]         frm_dlc,
  input  logic [63:0]        frm_data,
  input  logic               arm_we,
  input  logic [N_SLOTS-1:0] arm_mask,
  input  logic [SEL_W-1:0]   rd_sel,
  input  logic [1:0]         rd_word,
  output logic [31:0]        rd_data,
  output logic [N_SLOTS-1:0] ready_map,
  output logic               lost_flag
);

  localparam int LAST = N_SLOTS - 1;
  localparam logic [N_SLOTS-1:0] OVR_ONE = N_SLOTS'(1) << LAST;

  rx_frame_t          frame;
  logic [N_SLOTS-1:0] full_v, lost_v, clear_v, free_v, grant_v, tgt_v, store_v;
  logic               any_free;
  logic [WORD_W-1:0]  id_w   [N_SLOTS];
  logic [WORD_W-1:0]  stat_w [N_SLOTS];
  logic [WORD_W-1:0]  dlo_w  [N_SLOTS];
  logic [WORD_W-1:0]  dhi_w  [N_SLOTS];

  assign frm_ready = 1'b1;
  assign frame     = '{ext: frm_ext, id: frm_id, rtr: frm_rtr, dlc: frm_dlc, data: frm_data};

  // re-arm of this edge is counted before the search
  assign clear_v = arm_we ? arm_mask : '0;
  assign free_v  = ~full_v | clear_v;

  rxmb_pick #(.N(N_SLOTS)) u_pick (
    .free_i  (free_v),
    .grant_o (grant_v),
    .any_o   (any_free)
  );

  assign tgt_v   = any_free ? grant_v : OVR_ONE;
  assign store_v = frm_valid ? tgt_v : '0;

  for (genvar i = 0; i < N_SLOTS; i++) begin : g_slot
    localparam slot_mode_e M = (i == LAST) ? MODE_RX_OVR : MODE_RX;
    rxmb_slot #(.MODE(M)) u_slot (
      .clk         (clk),
      .rst_n       (rst_n),
      .store_i     (store_v[i]),
      .rearm_i     (clear_v[i]),
      .frame_i     (frame),
      .full_o      (full_v[i]),
      .lost_o      (lost_v[i]),
      .id_word_o   (id_w[i]),
      .stat_word_o (stat_w[i]),
      .dlo_o       (dlo_w[i]),
      .dhi_o       (dhi_w[i])
    );
  end

  always_comb begin
    rd_data = '0;
    if (int'(rd_sel) < N_SLOTS) begin
      case (word_sel_e'(rd_word))
        W_ID:    rd_data = id_w[rd_sel];
        W_STAT:  rd_data = stat_w[rd_sel];
        W_DLO:   rd_data = dlo_w[rd_sel];
        default: rd_data = dhi_w[rd_sel];
      endcase
    end
  end

  assign ready_map = full_v;
  assign lost_flag = lost_v[LAST];

  p_single_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(store_v));

  p_lowest_free_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && any_free) |-> (((store_v - 1'b1) & free_v) == '0) && ((store_v & free_v) == store_v));

  p_overwrite_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && !any_free) |=> (lost_flag && ready_map[LAST]));

  p_ready_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(ready_map) & ~$past(clear_v) & ~ready_map) == '0));

endmodule

// File: tb/rxmb_bank_bench.sv
module rxmb_bank_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frm_valid = 1'b0;
  logic        frm_ready;
  logic        frm_ext = 1'b0;
  logic [28:0] frm_id = '0;
  logic        frm_rtr = 1'b0;
  logic [3:0]  frm_dlc = '0;
  logic [63:0] frm_data = '0;
  logic        arm_we = 1'b0;
  logic [11:0] arm_mask = '0;
  logic [3:0]  rd_sel = '0;
  logic [1:0]  rd_word = '0;
  logic [31:0] rd_data;
  logic [11:0] ready_map;
  logic        lost_flag;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  int rot    = 0;

  // 125 MHz: 8 time-unit period
  always #4 clk = ~clk;

  rxmb_bank u_rxmb_bank (
    .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_ready(frm_ready),
    .frm_ext(frm_ext), .frm_id(frm_id), .frm_rtr(frm_rtr), .frm_dlc(frm_dlc),
    .frm_data(frm_data), .arm_we(arm_we), .arm_mask(arm_mask),
    .rd_sel(rd_sel), .rd_word(rd_word), .rd_data(rd_data),
    .ready_map(ready_map), .lost_flag(lost_flag)
  );

  // behavioural reference
  bit        m_full [12];
  bit        m_lost [12];
  bit [31:0] m_id   [12];
  bit        m_rtr  [12];
  bit [3:0]  m_dlc  [12];
  bit [63:0] m_data [12];

  function automatic bit [31:0] exp_word(int s, int w);
    if (s >= 12) return 32'h0;
    case (w)
      0: return m_id[s];
      1: return (32'(m_lost[s]) << 24) | (32'(m_full[s]) << 23) |
                (32'(m_rtr[s]) << 20) | (32'(m_dlc[s]) << 16);
      2: return m_data[s][31:0];
      default: return m_data[s][63:32];
    endcase
  endfunction

  function automatic bit [11:0] exp_map();
    bit [11:0] r;
    for (int i = 0; i < 12; i++) r[i] = m_full[i];
    return r;
  endfunction

  task automatic model_step();
    int s;
    if (arm_we)
      for (int i = 0; i < 12; i++)
        if (arm_mask[i]) begin m_full[i] = 0; m_lost[i] = 0; end
    if (frm_valid) begin
      s = -1;
      for (int i = 0; i < 12; i++) if (!m_full[i] && s < 0) s = i;
      if (s < 0) begin s = 11; m_lost[11] = 1; end
      else m_lost[s] = 0;
      m_full[s] = 1;
      m_id[s]   = frm_ext ? ((32'h1 << 29) | 32'(frm_id)) : (32'(frm_id[10:0]) << 18);
      m_rtr[s]  = frm_rtr;
      m_dlc[s]  = frm_dlc;
      m_data[s] = frm_data;
    end
  endtask

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // every-clock comparison against the model, one mailbox word per cycle
  task automatic compare_all();
    chk(ready_map == exp_map(), "R11 ready_map vs model", 32'(ready_map), 32'(exp_map()));
    chk(lost_flag == m_lost[11], "R7 lost_flag vs model", 32'(lost_flag), 32'(m_lost[11]));
    chk(frm_ready == 1'b1, "R12 frm_ready", 32'(frm_ready), 32'h1);
    rd_sel  = 4'(rot / 4);
    rd_word = 2'(rot % 4);
    #1;
    chk(rd_data == exp_word(rot / 4, rot % 4), "R3/R4/R5 rotating word vs model", rd_data,
        exp_word(rot / 4, rot % 4));
    rot = (rot + 1) % 48;
  endtask

  task automatic cyc(input bit v, input bit ext, input logic [28:0] id, input bit rtr,
                     input logic [3:0] dlc, input logic [63:0] data,
                     input bit we, input logic [11:0] mask);
    frm_valid = v; frm_ext = ext; frm_id = id; frm_rtr = rtr; frm_dlc = dlc; frm_data = data;
    arm_we = we; arm_mask = mask;
    @(posedge clk);
    model_step();
    @(negedge clk);
    frm_valid = 1'b0;
    arm_we    = 1'b0;
    compare_all();
  endtask

  task automatic frame(input bit ext, input logic [28:0] id, input bit rtr,
                       input logic [3:0] dlc, input logic [63:0] data);
    cyc(1'b1, ext, id, rtr, dlc, data, 1'b0, '0);
  endtask

  task automatic rearm(input logic [11:0] mask);
    cyc(1'b0, 1'b0, '0, 1'b0, '0, '0, 1'b1, mask);
  endtask

  task automatic peek(input int s, input int w, output logic [31:0] v);
    @(negedge clk);
    #2;
    rd_sel = 4'(s); rd_word = 2'(w);
    #1;
    v = rd_data;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired before the bench finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(ready_map == 12'h000, "R1 ready_map after reset", 32'(ready_map), 32'h0);
    chk(lost_flag == 1'b0, "R1 lost_flag after reset", 32'(lost_flag), 32'h0);
    peek(0, 1, v); chk(v == 32'h0, "R1 status of mailbox 0 after reset", v, 32'h0);
    peek(11, 0, v); chk(v == 32'h0, "R1 id of mailbox 11 after reset", v, 32'h0);

    // R2, R3, R4, R5 standard frame
    frame(1'b0, 29'h123, 1'b0, 4'd8, 64'h8877665544332211);
    chk(ready_map == 12'h001, "R2 first frame in mailbox 0", 32'(ready_map), 32'h1);
    peek(0, 0, v); chk(v == 32'h048C0000, "R3 standard id word", v, 32'h048C0000);
    peek(0, 1, v); chk(v == 32'h00880000, "R4 status dlc 8", v, 32'h00880000);
    peek(0, 2, v); chk(v == 32'h44332211, "R5 data low", v, 32'h44332211);
    peek(0, 3, v); chk(v == 32'h88776655, "R5 data high", v, 32'h88776655);

    // extended remote frame
    frame(1'b1, 29'h1ABCDEF0, 1'b1, 4'd0, 64'h0);
    chk(ready_map == 12'h003, "R2 second frame in mailbox 1", 32'(ready_map), 32'h3);
    peek(1, 0, v); chk(v == 32'h3ABCDEF0, "R3 extended id word", v, 32'h3ABCDEF0);
    peek(1, 1, v); chk(v == 32'h00900000, "R4 status remote dlc 0", v, 32'h00900000);

    // R8 reads do not free
    peek(0, 1, v); peek(0, 1, v); peek(1, 2, v);
    chk(ready_map == 12'h003, "R8 reads keep ready bits", 32'(ready_map), 32'h3);

    frame(1'b0, 29'h7FF, 1'b0, 4'd3, 64'h0000_0000_00C0FFEE);
    chk(ready_map == 12'h007, "R2 third frame in mailbox 2", 32'(ready_map), 32'h7);

    // R9 single re-arm keeps stored fields
    rearm(12'h002);
    chk(ready_map == 12'h005, "R9 re-arm mailbox 1 only", 32'(ready_map), 32'h5);
    peek(1, 1, v); chk(v == 32'h00100000, "R9 status after re-arm keeps rtr/dlc", v, 32'h00100000);
    peek(2, 1, v); chk(v[23] == ready_map[2], "R11 status bit 23 equals map bit", 32'(v[23]), 32'(ready_map[2]));

    // R6 lowest free
    frame(1'b0, 29'h055, 1'b0, 4'd1, 64'h5A);
    chk(ready_map == 12'h007, "R6 frame refills mailbox 1", 32'(ready_map), 32'h7);
    peek(1, 0, v); chk(v == (32'h055 << 18), "R6 mailbox 1 holds new id", v, 32'h055 << 18);

    for (int k = 3; k < 12; k++) frame(1'b0, 29'(k), 1'b0, 4'(k % 9), 64'(k));
    chk(ready_map == 12'hFFF, "R6 all twelve filled in order", 32'(ready_map), 32'hFFF);
    chk(lost_flag == 1'b0, "R7 no loss before overflow", 32'(lost_flag), 32'h0);

    // R7 overwrite
    frame(1'b1, 29'h5, 1'b0, 4'd2, 64'hAA55);
    chk(lost_flag == 1'b1, "R7 lost flag on overflow", 32'(lost_flag), 32'h1);
    peek(11, 1, v); chk(v == 32'h01820000, "R7 status of overwritten mailbox 11", v, 32'h01820000);
    peek(11, 0, v); chk(v == 32'h20000005, "R7 mailbox 11 content replaced", v, 32'h20000005);
    peek(10, 0, v); chk(v == (32'd10 << 18), "R7 mailbox 10 untouched", v, 32'd10 << 18);

    rearm(12'h800);
    chk(lost_flag == 1'b0, "R9 re-arm clears lost flag", 32'(lost_flag), 32'h0);
    chk(ready_map == 12'h7FF, "R9 re-arm of mailbox 11 only", 32'(ready_map), 32'h7FF);

    // R10 same-edge re-arm counts first
    cyc(1'b1, 1'b0, 29'h321, 1'b0, 4'd4, 64'h1234, 1'b1, 12'h010);
    chk(ready_map == 12'h7FF, "R10 frame lands in freshly freed mailbox 4", 32'(ready_map), 32'h7FF);
    peek(4, 0, v); chk(v == (32'h321 << 18), "R10 mailbox 4 holds the frame", v, 32'h321 << 18);

    rearm(12'h0FF);
    chk(ready_map == 12'h700, "R9 lower group re-armed", 32'(ready_map), 32'h700);

    // R12 valid low ignored, out-of-range reads
    cyc(1'b0, 1'b1, 29'h1FFFFFFF, 1'b1, 4'hF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, '0);
    chk(ready_map == 12'h700, "R12 frame with valid low ignored", 32'(ready_map), 32'h700);
    peek(0, 0, v); chk(v == 32'h048C0000, "R12 mailbox 0 unchanged by invalid frame", v, 32'h048C0000);
    for (int s = 12; s < 16; s++) begin
      peek(s, 1, v); chk(v == 32'h0, "R12 out-of-range index reads zero", v, 32'h0);
    end

    // mixed random traffic against the model
    for (int n = 0; n < 600; n++) begin
      cyc(($urandom % 10) < 6, $urandom % 2, 29'($urandom), $urandom % 2, 4'($urandom % 9),
          {32'($urandom), 32'($urandom)}, ($urandom % 5) == 0, 12'($urandom));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule